// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the management registers of a 10/100 Ethernet transceiver and serves them over a plain parallel access port. Each access names a PHY address and a register index. A write strobe carries 16 bits of data, and a read strobe returns 16 bits of data one clock later. The block answers only at its own PHY address, which is set by a parameter. Any other address reads as all ones and cannot change state.

Six registers carry content: control, status, two identifier words, local advertisement and link-partner ability. Control and advertisement are writable. The status and link-partner words are not stored. They are formed from a fixed capability pattern and a registered copy of an external link-up input, so a link change shows on the next clock without any software action. A control write with the reset bit set does not store the written value. It returns both writable registers to their defaults. Every other index, including the expansion word and the vendor range, reads as zero.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, read data is 0x0000, control reads 0x3100 (bit 13 speed 100, bit 12 autonegotiation enable, bit 8 full duplex) and advertisement (index 4) reads 0x01E1.
- R2: An access whose address differs from parameter OWN_ADDR reads 0xFFFF, and a write to it changes no register.
- R3: A write to control (index 0) with bit 15 clear stores the written value, and a later read returns it.
- R4: A write to control with bit 15 set stores nothing from the data. Control returns to 0x3100 and advertisement returns to 0x01E1.
- R5: A write to advertisement (index 4) stores the written value.
- R6: Status (index 1) reads 0x7848 while the registered link is down and 0x786C while it is up. Link up adds bit 2 (link) and bit 5 (autonegotiation complete).
- R7: Link-partner ability (index 5) reads 0x01E1 while the registered link is up and 0x0080 while it is down.
- R8: Writes to indices 1, 2, 3, 5 and 6 are ignored. Those registers, control and advertisement all keep their read values.
- R9: Indices 2 and 3 read the parameters ID_HI and ID_LO.
- R10: Any index other than 0 to 5 reads 0x0000 at the own address.
- R11: The registered link follows the link input one clock later. A read sampled on the same edge as a link change still sees the old link state.
- R12: Read data is registered. It updates on the edge where the read strobe is sampled and holds its value while no read is sampled. A read on the same edge as a write returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | Link state from the line side |
| acc_addr_i | input | ADDR_W | PHY address of the access |
| acc_reg_i | input | REG_W | Register index of the access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Registered read data |

## Verification
Control and advertisement hold the only stored software state. A corrupted value in either appears at the ports only when that register is next read, one clock after the read strobe. The bench therefore reads back after every write, including writes to read-only indices and to other addresses. A stale or misaligned link copy shows up as a wrong status or link-partner word on the first read after a link change. The bench places reads on the same edge as a link change and on the edge after it to pin that single cycle.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  typedef logic [15:0] word_t;

  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_STAT = 1;
  localparam int unsigned IDX_ID1  = 2;
  localparam int unsigned IDX_ID2  = 3;
  localparam int unsigned IDX_ADV  = 4;
  localparam int unsigned IDX_LP   = 5;

  localparam int unsigned CTRL_RST_BIT = 15;

  localparam word_t CTRL_DEFAULT = 16'h3100;
  localparam word_t ADV_DEFAULT  = 16'h01E1;
  localparam word_t STAT_BASE    = 16'h7848;
  localparam word_t STAT_LINKED  = 16'h0024;
  localparam word_t LP_UP        = 16'h01E1;
  localparam word_t LP_DOWN      = 16'h0080;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_STAT, SEL_ID1, SEL_ID2, SEL_ADV, SEL_LP, SEL_ZERO, SEL_NOPHY
  } sel_e;
endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned OWN_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  reg_i,
  output sel_e              sel_o
);
  always_comb begin
    if (addr_i != ADDR_W'(OWN_ADDR)) begin
      sel_o = SEL_NOPHY;
    end else begin
      unique case (reg_i)
        REG_W'(IDX_CTRL): sel_o = SEL_CTRL;
        REG_W'(IDX_STAT): sel_o = SEL_STAT;
        REG_W'(IDX_ID1):  sel_o = SEL_ID1;
        REG_W'(IDX_ID2):  sel_o = SEL_ID2;
        REG_W'(IDX_ADV):  sel_o = SEL_ADV;
        REG_W'(IDX_LP):   sel_o = SEL_LP;
        default:          sel_o = SEL_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/phy_mgmt_wregs.sv
module phy_mgmt_wregs
  import phy_mgmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en_i,
  input  sel_e  sel_i,
  input  word_t wr_data_i,
  output word_t ctrl_o,
  output word_t adv_o
);
  word_t ctrl_q, ctrl_d, adv_q, adv_d;
  logic  ctrl_en, adv_en;

  always_comb begin
    ctrl_en = 1'b0;
    adv_en  = 1'b0;
    ctrl_d  = ctrl_q;
    adv_d   = adv_q;
    if (wr_en_i) begin
      if (sel_i == SEL_CTRL) begin
        ctrl_en = 1'b1;
        if (wr_data_i[CTRL_RST_BIT]) begin
          ctrl_d = CTRL_DEFAULT;
          adv_en = 1'b1;
          adv_d  = ADV_DEFAULT;
        end else begin
          ctrl_d = wr_data_i;
        end
      end else if (sel_i == SEL_ADV) begin
        adv_en = 1'b1;
        adv_d  = wr_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEFAULT;
      adv_q  <= ADV_DEFAULT;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (adv_en)  adv_q  <= adv_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign adv_o  = adv_q;
endmodule

// File: rtl/phy_mgmt_link.sv
module phy_mgmt_link (
  input  logic clk,
  input  logic rst_n,
  input  logic link_i,
  output logic link_o
);
  logic link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_i;
  end

  assign link_o = link_q;
endmodule

// File: rtl/phy_mgmt_rdmux.sv
module phy_mgmt_rdmux
  import phy_mgmt_pkg::*;
#(
  parameter word_t ID_HI = 16'h0022,
  parameter word_t ID_LO = 16'h1570
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_en_i,
  input  sel_e  sel_i,
  input  word_t ctrl_i,
  input  word_t adv_i,
  input  logic  link_i,
  output word_t rd_data_o
);
  word_t stat_w, lp_w, rd_d, rd_q;

  always_comb begin
    stat_w = link_i ? (STAT_BASE | STAT_LINKED) : STAT_BASE;
    lp_w   = link_i ? LP_UP : LP_DOWN;
    unique case (sel_i)
      SEL_CTRL:  rd_d = ctrl_i;
      SEL_STAT:  rd_d = stat_w;
      SEL_ID1:   rd_d = ID_HI;
      SEL_ID2:   rd_d = ID_LO;
      SEL_ADV:   rd_d = adv_i;
      SEL_LP:    rd_d = lp_w;
      SEL_NOPHY: rd_d = 16'hFFFF;
      default:   rd_d = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= 16'h0000;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned OWN_ADDR = 1,
  parameter logic [15:0] ID_HI    = 16'h0022,
  parameter logic [15:0] ID_LO    = 16'h1570
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [REG_W-1:0]  acc_reg_i,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_data_i,
  input  logic              rd_en_i,
  output logic [15:0]       rd_data_o
);
  sel_e  sel;
  word_t ctrl_q, adv_q;
  logic  link_q;

  phy_mgmt_decode #(.ADDR_W(ADDR_W), .REG_W(REG_W), .OWN_ADDR(OWN_ADDR)) u_dec (
    .addr_i(acc_addr_i), .reg_i(acc_reg_i), .sel_o(sel)
  );

  phy_mgmt_wregs u_wregs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .sel_i(sel),
    .wr_data_i(wr_data_i), .ctrl_o(ctrl_q), .adv_o(adv_q)
  );

  phy_mgmt_link u_link (
    .clk(clk), .rst_n(rst_n), .link_i(link_up_i), .link_o(link_q)
  );

  phy_mgmt_rdmux #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .sel_i(sel),
    .ctrl_i(ctrl_q), .adv_i(adv_q), .link_i(link_q), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned OWN_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_up_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic [REG_W-1:0]  acc_reg_i,
  input logic              wr_en_i,
  input logic [15:0]       wr_data_i,
  input logic              rd_en_i,
  input logic [15:0]       rd_data_o,
  input logic [15:0]       ctrl_q,
  input logic [15:0]       adv_q,
  input logic              link_q
);
  logic own, w_ctrl, w_adv;
  assign own    = (acc_addr_i == ADDR_W'(OWN_ADDR));
  assign w_ctrl = wr_en_i && own && (acc_reg_i == REG_W'(0));
  assign w_adv  = wr_en_i && own && (acc_reg_i == REG_W'(4));

  assert_foreign_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !own) |=> (rd_data_o == 16'hFFFF));

  assert_foreign_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !own) |=> ($stable(ctrl_q) && $stable(adv_q)));

  assert_ctrl_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && !wr_data_i[15]) |=> (ctrl_q == $past(wr_data_i)));

  assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && wr_data_i[15]) |=> (ctrl_q == 16'h3100 && adv_q == 16'h01E1));

  assert_ro_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !w_ctrl && !w_adv) |=> ($stable(ctrl_q) && $stable(adv_q)));

  assert_link_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (link_q == $past(link_up_i)));

  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind phy_mgmt_regfile phy_mgmt_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .OWN_ADDR(OWN_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_up_i(link_up_i), .acc_addr_i(acc_addr_i),
  .acc_reg_i(acc_reg_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .ctrl_q(ctrl_q), .adv_q(adv_q),
  .link_q(link_q)
);

// File: tb/phy_mgmt_regfile_tb.sv
module phy_mgmt_regfile_tb;
  localparam int unsigned AW  = 5;
  localparam int unsigned RW  = 5;
  localparam int unsigned OWN = 1;
  localparam logic [15:0] IDH = 16'h1234;
  localparam logic [15:0] IDL = 16'hABCD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [RW-1:0] rg = '0;
  logic we = 1'b0, re = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rd;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_ctrl, m_adv;
  logic m_link;

  always #2.5 clk = ~clk;

  phy_mgmt_regfile #(.ADDR_W(AW), .REG_W(RW), .OWN_ADDR(OWN), .ID_HI(IDH), .ID_LO(IDL)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_up_i(link), .acc_addr_i(addr), .acc_reg_i(rg),
    .wr_en_i(we), .wr_data_i(wd), .rd_en_i(re), .rd_data_o(rd)
  );

  function automatic logic [15:0] exp_rd(input logic [AW-1:0] a, input logic [RW-1:0] r);
    if (a != AW'(OWN)) return 16'hFFFF;
    case (r)
      RW'(0): return m_ctrl;
      RW'(1): return m_link ? 16'h786C : 16'h7848;
      RW'(2): return IDH;
      RW'(3): return IDL;
      RW'(4): return m_adv;
      RW'(5): return m_link ? 16'h01E1 : 16'h0080;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_wr(input logic [AW-1:0] a, input logic [RW-1:0] r, input logic [15:0] d);
    if (a == AW'(OWN)) begin
      if (r == RW'(0)) begin
        if (d[15]) begin m_ctrl = 16'h3100; m_adv = 16'h01E1; end
        else m_ctrl = d;
      end else if (r == RW'(4)) m_adv = d;
    end
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [RW-1:0] r, input logic [15:0] d);
    @(negedge clk);
    addr = a; rg = r; wd = d; we = 1'b1; re = 1'b0;
    @(negedge clk);
    we = 1'b0;
    model_wr(a, r, d);
  endtask

  task automatic do_rd(input logic [AW-1:0] a, input logic [RW-1:0] r, output logic [15:0] d);
    @(negedge clk);
    addr = a; rg = r; re = 1'b1; we = 1'b0;
    @(negedge clk);
    re = 1'b0;
    d = rd;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [RW-1:0] r);
    logic [15:0] d;
    logic [15:0] e;
    e = exp_rd(a, r);
    do_rd(a, r, d);
    check(tag, d, e);
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    link = v;
    @(negedge clk);
    m_link = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, held;
    m_ctrl = 16'h3100; m_adv = 16'h01E1; m_link = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data after reset", rd, 16'h0000);
    rd_chk("R1 control default", AW'(OWN), 0);
    rd_chk("R1 advert default", AW'(OWN), 4);
    rd_chk("R6 status link down", AW'(OWN), 1);
    rd_chk("R7 partner link down", AW'(OWN), 5);
    rd_chk("R9 id hi", AW'(OWN), 2);
    rd_chk("R9 id lo", AW'(OWN), 3);
    rd_chk("R10 expansion zero", AW'(OWN), 6);
    rd_chk("R10 vendor zero", AW'(OWN), 16);
    rd_chk("R2 foreign read", AW'(OWN + 1), 0);

    // R3 / R5 stores
    do_wr(AW'(OWN), 0, 16'h0100);
    rd_chk("R3 control store", AW'(OWN), 0);
    do_wr(AW'(OWN), 4, 16'h0061);
    rd_chk("R5 advert store", AW'(OWN), 4);
    // R2 foreign write ignored
    do_wr(AW'(OWN + 3), 0, 16'h1234);
    rd_chk("R2 foreign write ctrl", AW'(OWN), 0);
    do_wr(AW'(0), 4, 16'h0000);
    rd_chk("R2 foreign write adv", AW'(OWN), 4);
    // R8 read-only
    for (int i = 0; i < 5; i++) begin
      logic [RW-1:0] ro;
      ro = (i == 0) ? RW'(1) : (i == 1) ? RW'(2) : (i == 2) ? RW'(3) : (i == 3) ? RW'(5) : RW'(6);
      do_wr(AW'(OWN), ro, 16'h5A5A);
      rd_chk("R8 read-only index", AW'(OWN), ro);
    end
    rd_chk("R8 control kept", AW'(OWN), 0);
    rd_chk("R8 advert kept", AW'(OWN), 4);
    // R4 soft reset
    do_wr(AW'(OWN), 0, 16'hFFFF);
    rd_chk("R4 control restored", AW'(OWN), 0);
    rd_chk("R4 advert restored", AW'(OWN), 4);

    // R11 same-edge read sees old link, next sees new
    @(negedge clk);
    link = 1'b1; addr = AW'(OWN); rg = 1; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    check("R11 same-edge old link", rd, 16'h7848);
    m_link = 1'b1;
    rd_chk("R11 status after link up", AW'(OWN), 1);
    rd_chk("R7 partner link up", AW'(OWN), 5);
    rd_chk("R6 status link up", AW'(OWN), 1);

    // R12 hold while idle, and read-before-write on one edge
    held = rd;
    set_link(1'b0);
    repeat (3) @(negedge clk);
    check("R12 hold with no read", rd, held);
    @(negedge clk);
    addr = AW'(OWN); rg = 0; wd = 16'h2000; we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    check("R12 read before write", rd, m_ctrl);
    model_wr(AW'(OWN), 0, 16'h2000);
    rd_chk("R3 control after same-edge write", AW'(OWN), 0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [AW-1:0] a;
      logic [RW-1:0] r;
      logic [15:0] v;
      op = $urandom % 10;
      a = ($urandom % 4 != 0) ? AW'(OWN) : AW'($urandom);
      r = ($urandom % 5 != 0) ? RW'($urandom % 7) : RW'($urandom);
      v = 16'($urandom);
      if (op < 4) do_wr(a, r, v);
      else if (op < 9) rd_chk("R2-R10 random read", a, r);
      else set_link(~m_link);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule